// File: doc/BRIEF.md
# Operand Addressing Extension Fetcher

This block takes one 16-bit opcode and resolves one of its two 6-bit operand addressing fields, each made of a 3-bit mode and a 3-bit register number. From mode, register and the operand size given with the start request, it works out how many extension words follow the opcode: none, one or two. It reads those words in order from a big-endian 16-bit instruction stream through a valid/ready word request port, one word per handshake, starting at the supplied program counter.

The result is an operand-kind code, the base register number, a 32-bit extension value, and the fields of an index word when the mode uses one. The extension value is a sign-extended displacement, a sign-extended short absolute address, a 32-bit long absolute address or an immediate. An illegal flag marks mode/register/size combinations that have no meaning. A decode stage pulses the start input once per operand and waits for the done pulse. Computing the effective address, reading operand memory and accessing the register file are left to later stages.

Top module: `opnd_ext_fetcher`

## Requirements
- R1: With `start_dest`=0 the field is read with mode = opcode bits 5:3 and register = bits 2:0. With `start_dest`=1 it is read with register = bits 11:9 and mode = bits 8:6. `base_reg` reports the selected register number.
- R2: Modes 0..4 fetch no word. They report kind codes 0 (data register), 1 (address register), 2 (register indirect), 3 (indirect, post-increment) and 4 (indirect, pre-decrement). `done` is high in the same cycle as the accepted start, and `ext_value` is zero.
- R3: Mode 5 (kind 5) and mode 7 with register 2 (kind 9, program-counter relative) fetch one word. `ext_value` is that word sign-extended from 16 to 32 bits.
- R4: Mode 6 (kind 6) and mode 7 with register 3 (kind 10) fetch one index word. `ext_value` is its bits 7:0 sign-extended to 32 bits. `idx_reg` is bits 14:12. `idx_long` is bit 11 (1 = long index). `idx_areg` is bit 15 (1 = address register). Every other mode reports all three index outputs as zero.
- R5: Mode 7 with register 0 (kind 7) fetches one word and sign-extends it. Mode 7 with register 1 (kind 8) fetches two words, and `ext_value` is the first word in bits 31:16 and the second in bits 15:0.
- R6: Mode 7 with register 4 is an immediate (kind 11). The size code is 00 byte, 01 word, 10 long, 11 none. Size 00 or 01 fetches one word, zero-extended. Size 10 fetches two words, high-order word first. Size 11 fetches nothing and is illegal.
- R7: Mode 7 with register 5, 6 or 7, and the sizeless immediate, report kind 15 and raise `illegal` with `done` in the start cycle, with no word fetched.
- R8: The n-th extension word (n from 0) is requested at address `start_pc` + 2n. After completion `pc_next` equals `start_pc` plus twice the number of words fetched (modulo 2^32).
- R9: When words are needed, `done` pulses for exactly one cycle, in the cycle after the handshake of the last word.
- R10: While `req_ready` is low the request stays up with an unchanged address, and no word is consumed.
- R11: A start is ignored while a fetch is running. All result outputs hold their values until the next accepted start. After reset `done`, `illegal` and `req_valid` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Request to resolve a field; taken when no fetch runs |
| start_dest | input | 1 | 0 = low (source) field, 1 = swapped high (destination) field |
| start_size | input | 2 | Operand size: 00 byte, 01 word, 10 long, 11 none |
| start_opcode | input | 16 | Opcode word holding the field |
| start_pc | input | 32 | Address of the first extension word |
| req_valid | output | 1 | Extension word request |
| req_ready | input | 1 | Word on `req_data` is valid this cycle |
| req_addr | output | 32 | Address of the requested word |
| req_data | input | 16 | Returned instruction word |
| done | output | 1 | Result complete |
| illegal | output | 1 | Field combination is illegal |
| opnd_kind | output | 4 | Operand kind code |
| base_reg | output | 3 | Register number from the field |
| ext_value | output | 32 | Displacement, absolute address or immediate |
| idx_reg | output | 3 | Index register number |
| idx_long | output | 1 | Index register used as long |
| idx_areg | output | 1 | Index register is an address register |
| pc_next | output | 32 | Address after the last extension word |

## Verification
The results of zero-word modes, illegal combinations included, are due combinationally in the cycle of the start. The bench drives start on a falling edge and samples a nanosecond later, before the rising edge that accepts it. For fetching modes the bench records the cycle of every handshake it sees, checks each request address as it arrives, and expects `done` and the final result exactly one cycle after the last handshake, whatever the random back-pressure did. A second sample one cycle later confirms the pulse has ended and the results are held. The sweep covers both field positions, every mode, register and size code, with stalls on half of the cases and a stray start injected during some fetches.

// File: rtl/opnd_pkg.sv
`timescale 1ns/1ps
package opnd_pkg;

   typedef enum logic [3:0] {
      OK_DREG   = 4'd0,
      OK_AREG   = 4'd1,
      OK_AIND   = 4'd2,
      OK_APOST  = 4'd3,
      OK_APRE   = 4'd4,
      OK_ADISP  = 4'd5,
      OK_AIDX   = 4'd6,
      OK_ABSW   = 4'd7,
      OK_ABSL   = 4'd8,
      OK_PCDISP = 4'd9,
      OK_PCIDX  = 4'd10,
      OK_IMM    = 4'd11,
      OK_BAD    = 4'd15
   } opnd_kind_e;

   // how the fetched word(s) become the extension value
   typedef enum logic [1:0] {
      FMT_SEXT = 2'd0,
      FMT_ZEXT = 2'd1,
      FMT_IDX  = 2'd2,
      FMT_PAIR = 2'd3
   } word_fmt_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_NONE = 2'd3
   } opnd_size_e;

   typedef struct packed {
      opnd_kind_e kind;
      logic [1:0] nwords;
      word_fmt_e  fmt;
      logic       bad;
   } mode_info_t;

endpackage

// File: rtl/opnd_field_sel.sv
`timescale 1ns/1ps
module opnd_field_sel #(
   parameter int OP_W = 16,
   parameter int F_W  = 3
) (
   input  logic [OP_W-1:0] opcode,
   input  logic            dest,
   output logic [F_W-1:0]  mode,
   output logic [F_W-1:0]  regn
);
   localparam int SRC_REG_LSB  = 0;
   localparam int SRC_MODE_LSB = F_W;
   localparam int DST_MODE_LSB = 2 * F_W;
   localparam int DST_REG_LSB  = 3 * F_W;

   if (OP_W < 4 * F_W) begin : g_bad_width
      $error("opnd_field_sel: opcode too narrow for two fields");
   end

   logic [F_W-1:0] src_mode, src_reg, dst_mode, dst_reg;

   assign src_mode = opcode[SRC_MODE_LSB +: F_W];
   assign src_reg  = opcode[SRC_REG_LSB  +: F_W];
   assign dst_mode = opcode[DST_MODE_LSB +: F_W];
   assign dst_reg  = opcode[DST_REG_LSB  +: F_W];

   always_comb begin
      if (dest) begin
         mode = dst_mode;
         regn = dst_reg;
      end else begin
         mode = src_mode;
         regn = src_reg;
      end
   end
endmodule

// File: rtl/opnd_mode_dec.sv
`timescale 1ns/1ps
module opnd_mode_dec
   import opnd_pkg::*;
#(
   parameter int F_W = 3
) (
   input  logic [F_W-1:0] mode,
   input  logic [F_W-1:0] regn,
   input  logic [1:0]     size,
   output mode_info_t     info
);
   if (F_W != 3) begin : g_bad_field
      $error("opnd_mode_dec: field width must be 3");
   end

   always_comb begin
      info.kind   = OK_BAD;
      info.nwords = 2'd0;
      info.fmt    = FMT_SEXT;
      info.bad    = 1'b0;
      unique case (mode)
         3'd0: info.kind = OK_DREG;
         3'd1: info.kind = OK_AREG;
         3'd2: info.kind = OK_AIND;
         3'd3: info.kind = OK_APOST;
         3'd4: info.kind = OK_APRE;
         3'd5: begin
            info.kind   = OK_ADISP;
            info.nwords = 2'd1;
         end
         3'd6: begin
            info.kind   = OK_AIDX;
            info.nwords = 2'd1;
            info.fmt    = FMT_IDX;
         end
         default: begin
            unique case (regn)
               3'd0: begin
                  info.kind   = OK_ABSW;
                  info.nwords = 2'd1;
               end
               3'd1: begin
                  info.kind   = OK_ABSL;
                  info.nwords = 2'd2;
                  info.fmt    = FMT_PAIR;
               end
               3'd2: begin
                  info.kind   = OK_PCDISP;
                  info.nwords = 2'd1;
               end
               3'd3: begin
                  info.kind   = OK_PCIDX;
                  info.nwords = 2'd1;
                  info.fmt    = FMT_IDX;
               end
               3'd4: begin
                  if (size == SZ_NONE) begin
                     info.bad = 1'b1;
                  end else if (size == SZ_LONG) begin
                     info.kind   = OK_IMM;
                     info.nwords = 2'd2;
                     info.fmt    = FMT_PAIR;
                  end else begin
                     info.kind   = OK_IMM;
                     info.nwords = 2'd1;
                     info.fmt    = FMT_ZEXT;
                  end
               end
               default: info.bad = 1'b1;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/opnd_word_asm.sv
`timescale 1ns/1ps
module opnd_word_asm
   import opnd_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int VAL_W    = 32,
   parameter int PC_W     = 32,
   parameter int DISP8_W  = 8,
   parameter int IDX_W    = 3,
   parameter bit IMM_SEXT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [1:0]        nwords,
   input  word_fmt_e         fmt,
   input  logic [PC_W-1:0]   start_pc,
   output logic              req_valid,
   input  logic              req_ready,
   input  logic [WORD_W-1:0] req_data,
   output logic [PC_W-1:0]   pc_q,
   output logic [VAL_W-1:0]  val_q,
   output logic [IDX_W-1:0]  idx_reg_q,
   output logic              idx_long_q,
   output logic              idx_areg_q,
   output logic              busy_q,
   output logic [1:0]        left_q,
   output logic              done_q
);
   localparam int BYTES_PER_WORD = WORD_W / 8;
   localparam int IDX_TYPE_BIT   = WORD_W - 1;
   localparam int IDX_REG_LSB    = WORD_W - 1 - IDX_W;
   localparam int IDX_SIZE_BIT   = IDX_REG_LSB - 1;
   localparam int HI_LSB         = VAL_W - WORD_W;

   if (VAL_W != 2 * WORD_W) begin : g_bad_val
      $error("opnd_word_asm: value must be exactly two words");
   end
   if (DISP8_W > IDX_SIZE_BIT) begin : g_bad_disp
      $error("opnd_word_asm: short displacement overlaps index fields");
   end

   word_fmt_e        fmt_q;
   logic             hs;
   logic [VAL_W-1:0] sext_word, sext_short, short_imm, one_word_val;

   assign req_valid  = busy_q;
   assign hs         = busy_q && req_ready;
   assign sext_word  = {{(VAL_W-WORD_W){req_data[WORD_W-1]}}, req_data};
   assign sext_short = {{(VAL_W-DISP8_W){req_data[DISP8_W-1]}}, req_data[DISP8_W-1:0]};

   if (IMM_SEXT) begin : g_imm_sext
      assign short_imm = sext_word;
   end else begin : g_imm_zext
      assign short_imm = {{(VAL_W-WORD_W){1'b0}}, req_data};
   end

   always_comb begin
      unique case (fmt_q)
         FMT_SEXT: one_word_val = sext_word;
         FMT_ZEXT: one_word_val = short_imm;
         FMT_IDX:  one_word_val = sext_short;
         default:  one_word_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         left_q     <= 2'd0;
         done_q     <= 1'b0;
         fmt_q      <= FMT_SEXT;
         pc_q       <= '0;
         val_q      <= '0;
         idx_reg_q  <= '0;
         idx_long_q <= 1'b0;
         idx_areg_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q     <= (nwords != 2'd0);
            left_q     <= nwords;
            fmt_q      <= fmt;
            pc_q       <= start_pc;
            val_q      <= '0;
            idx_reg_q  <= '0;
            idx_long_q <= 1'b0;
            idx_areg_q <= 1'b0;
         end else if (hs) begin
            pc_q   <= pc_q + PC_W'(BYTES_PER_WORD);
            left_q <= left_q - 2'd1;
            if (left_q == 2'd1) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
            if (fmt_q == FMT_PAIR) begin
               if (left_q == 2'd2) val_q[VAL_W-1:HI_LSB] <= req_data;
               else                val_q[WORD_W-1:0]    <= req_data;
            end else begin
               val_q <= one_word_val;
            end
            if (fmt_q == FMT_IDX) begin
               idx_reg_q  <= req_data[IDX_REG_LSB +: IDX_W];
               idx_long_q <= req_data[IDX_SIZE_BIT];
               idx_areg_q <= req_data[IDX_TYPE_BIT];
            end
         end
      end
   end
endmodule

// File: rtl/opnd_ext_fetcher.sv
`timescale 1ns/1ps
module opnd_ext_fetcher
   import opnd_pkg::*;
#(
   parameter int OP_W     = 16,
   parameter int WORD_W   = 16,
   parameter int PC_W     = 32,
   parameter int F_W      = 3,
   parameter bit IMM_SEXT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   input  logic              start_dest,
   input  logic [1:0]        start_size,
   input  logic [OP_W-1:0]   start_opcode,
   input  logic [PC_W-1:0]   start_pc,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [PC_W-1:0]   req_addr,
   input  logic [WORD_W-1:0] req_data,
   output logic              done,
   output logic              illegal,
   output logic [3:0]        opnd_kind,
   output logic [F_W-1:0]    base_reg,
   output logic [2*WORD_W-1:0] ext_value,
   output logic [F_W-1:0]    idx_reg,
   output logic              idx_long,
   output logic              idx_areg,
   output logic [PC_W-1:0]   pc_next
);
   localparam int VAL_W = 2 * WORD_W;

   logic [F_W-1:0]   fld_mode, fld_reg;
   mode_info_t       info;
   logic             accept, zero_now;
   logic             busy_w, done_q;
   logic [1:0]       left_w;
   logic [PC_W-1:0]  pc_q;
   logic [VAL_W-1:0] val_q;
   logic [F_W-1:0]   idx_reg_q;
   logic             idx_long_q, idx_areg_q;
   opnd_kind_e       kind_q;
   logic [F_W-1:0]   base_q;
   logic             bad_q;

   opnd_field_sel #(.OP_W(OP_W), .F_W(F_W)) u_sel (
      .opcode (start_opcode),
      .dest   (start_dest),
      .mode   (fld_mode),
      .regn   (fld_reg)
   );

   opnd_mode_dec #(.F_W(F_W)) u_dec (
      .mode (fld_mode),
      .regn (fld_reg),
      .size (start_size),
      .info (info)
   );

   assign accept   = start_valid && !busy_w;
   assign zero_now = accept && (info.nwords == 2'd0);

   opnd_word_asm #(
      .WORD_W   (WORD_W),
      .VAL_W    (VAL_W),
      .PC_W     (PC_W),
      .IDX_W    (F_W),
      .IMM_SEXT (IMM_SEXT)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .nwords     (info.nwords),
      .fmt        (info.fmt),
      .start_pc   (start_pc),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_data   (req_data),
      .pc_q       (pc_q),
      .val_q      (val_q),
      .idx_reg_q  (idx_reg_q),
      .idx_long_q (idx_long_q),
      .idx_areg_q (idx_areg_q),
      .busy_q     (busy_w),
      .left_q     (left_w),
      .done_q     (done_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= OK_DREG;
         base_q <= '0;
         bad_q  <= 1'b0;
      end else if (accept) begin
         kind_q <= info.kind;
         base_q <= fld_reg;
         bad_q  <= info.bad;
      end
   end

   assign req_addr  = pc_q;
   assign done      = done_q || zero_now;
   assign illegal   = zero_now ? info.bad : bad_q;
   assign opnd_kind = zero_now ? info.kind : kind_q;
   assign base_reg  = zero_now ? fld_reg : base_q;
   assign ext_value = zero_now ? '0 : val_q;
   assign idx_reg   = zero_now ? '0 : idx_reg_q;
   assign idx_long  = zero_now ? 1'b0 : idx_long_q;
   assign idx_areg  = zero_now ? 1'b0 : idx_areg_q;
   assign pc_next   = zero_now ? start_pc : pc_q;
endmodule

// File: rtl/opnd_ext_fetcher_chk.sv
`timescale 1ns/1ps
module opnd_ext_fetcher_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_valid,
   input logic            req_valid,
   input logic            req_ready,
   input logic            done,
   input logic            illegal,
   input logic            busy_w,
   input logic [1:0]      left_w,
   input logic [PC_W-1:0] pc_q,
   input logic [3:0]      opnd_kind
);
   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && left_w == 2'd1) |=> done);

   assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done || start_valid));

   assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (pc_q == $past(pc_q) + PC_W'(2)));

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(pc_q)));

   assert_illegal_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(illegal) |-> done);

   assert_kind_held_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && $past(busy_w)) |-> $stable(opnd_kind));

   assert_no_fetch_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);
endmodule

bind opnd_ext_fetcher opnd_ext_fetcher_chk #(.PC_W(PC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_valid (start_valid),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .done        (done),
   .illegal     (illegal),
   .busy_w      (busy_w),
   .left_w      (left_w),
   .pc_q        (pc_q),
   .opnd_kind   (opnd_kind)
);

// File: tb/opnd_ext_fetcher_test.sv
`timescale 1ns/1ps
module opnd_ext_fetcher_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0;
   logic        start_dest = 1'b0;
   logic [1:0]  start_size = 2'd0;
   logic [15:0] start_opcode = 16'd0;
   logic [31:0] start_pc = 32'd0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr;
   logic [15:0] req_data;
   logic        done, illegal, idx_long, idx_areg;
   logic [3:0]  opnd_kind;
   logic [2:0]  base_reg, idx_reg;
   logic [31:0] ext_value, pc_next;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   function automatic logic [15:0] wd(input logic [31:0] a);
      return (a[15:0] * 16'h9E37) ^ a[31:16] ^ 16'h5A3C;
   endfunction

   assign req_data = wd(req_addr);

   opnd_ext_fetcher uut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_dest(start_dest),
      .start_size(start_size), .start_opcode(start_opcode), .start_pc(start_pc),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
      .done(done), .illegal(illegal), .opnd_kind(opnd_kind), .base_reg(base_reg),
      .ext_value(ext_value), .idx_reg(idx_reg), .idx_long(idx_long), .idx_areg(idx_areg),
      .pc_next(pc_next)
   );

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cycles == 150000) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL R9 watchdog act=%0d exp=%0d", cycles, 0);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // reference model computed from the requirements
   function automatic int exp_words(input int m, input int r, input int sz);
      if (m < 5) return 0;
      if (m < 7) return 1;
      case (r)
         0, 2, 3: return 1;
         1: return 2;
         4: return (sz == 3) ? 0 : ((sz == 2) ? 2 : 1);
         default: return 0;
      endcase
   endfunction

   function automatic logic [3:0] exp_kind(input int m, input int r, input int sz);
      if (m < 7) return 4'(m);
      case (r)
         0: return 4'd7;
         1: return 4'd8;
         2: return 4'd9;
         3: return 4'd10;
         4: return (sz == 3) ? 4'd15 : 4'd11;
         default: return 4'd15;
      endcase
   endfunction

   task automatic run_case(input bit dst, input int m, input int r, input int sz,
                           input logic [31:0] pc, input bit stall, input bit poke);
      logic [15:0] op, w0, w1;
      logic [31:0] ev;
      logic [3:0]  ek;
      int nw, hs, last, cyc;
      bit got, isidx, ill;
      op = lfsr ^ 16'h3C5A;
      if (dst) begin
         op[11:9] = 3'(r);
         op[8:6]  = 3'(m);
      end else begin
         op[5:3] = 3'(m);
         op[2:0] = 3'(r);
      end
      nw = exp_words(m, r, sz);
      ek = exp_kind(m, r, sz);
      ill = (ek == 4'd15);
      isidx = (m == 6) || (m == 7 && r == 3);
      w0 = wd(pc);
      w1 = wd(pc + 32'd2);
      ev = 32'd0;
      if (m == 5 || (m == 7 && (r == 0 || r == 2))) ev = {{16{w0[15]}}, w0};
      if (isidx) ev = {{24{w0[7]}}, w0[7:0]};
      if (m == 7 && r == 1) ev = {w0, w1};
      if (m == 7 && r == 4 && sz == 2) ev = {w0, w1};
      if (m == 7 && r == 4 && sz < 2) ev = {16'd0, w0};

      @(negedge clk);
      start_valid = 1'b1;
      start_dest = dst;
      start_size = 2'(sz);
      start_opcode = op;
      start_pc = pc;
      #1;
      if (nw == 0) begin
         chk(done == 1'b1, "R2 done same cycle", 32'(done), 32'd1);
         chk(opnd_kind == ek, ill ? "R7 kind" : "R2 kind", 32'(opnd_kind), 32'(ek));
         chk(base_reg == 3'(r), "R1 base reg", 32'(base_reg), 32'(r));
         chk(illegal == ill, "R7 illegal flag", 32'(illegal), 32'(ill));
         chk(ext_value == 32'd0, "R2 value zero", ext_value, 32'd0);
         chk(req_valid == 1'b0, "R7 no fetch", 32'(req_valid), 32'd0);
         chk(pc_next == pc, "R8 pc unchanged", pc_next, pc);
         @(negedge clk);
         start_valid = 1'b0;
         #1;
         chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
         chk(opnd_kind == ek && base_reg == 3'(r) && illegal == ill, "R11 held",
             {24'd0, opnd_kind, illegal, base_reg}, {24'd0, ek, ill, 3'(r)});
      end else begin
         chk(done == 1'b0, "R9 no early done", 32'(done), 32'd0);
         hs = 0; last = -10; cyc = 0; got = 1'b0;
         while (!got && cyc < 60) begin
            @(negedge clk);
            start_valid = (cyc == 0) ? poke : 1'b0;
            if (poke) begin
               start_opcode = ~op;
               start_size = 2'd3;
            end
            req_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
            #1;
            if (done) begin
               got = 1'b1;
               chk(cyc == last + 1, "R9 done timing", 32'(cyc), 32'(last + 1));
            end else if (req_valid) begin
               chk(req_addr == pc + 32'(2 * hs), "R10 R8 request address", req_addr, pc + 32'(2 * hs));
               if (req_ready) begin
                  hs = hs + 1;
                  if (hs == nw) last = cyc;
               end
            end
            cyc = cyc + 1;
         end
         chk(got, "R9 done seen", 32'(got), 32'd1);
         chk(hs == nw, "R5 R6 word count", 32'(hs), 32'(nw));
         chk(opnd_kind == ek, "R3 R5 R6 kind", 32'(opnd_kind), 32'(ek));
         chk(base_reg == 3'(r), "R1 base reg", 32'(base_reg), 32'(r));
         chk(ext_value == ev, isidx ? "R4 displacement" : "R3 R5 R6 value", ext_value, ev);
         chk(illegal == 1'b0, "R7 legal", 32'(illegal), 32'd0);
         chk(pc_next == pc + 32'(2 * nw), "R8 pc next", pc_next, pc + 32'(2 * nw));
         if (isidx)
            chk(idx_reg == w0[14:12] && idx_long == w0[11] && idx_areg == w0[15], "R4 index fields",
                {27'd0, idx_areg, idx_long, idx_reg}, {27'd0, w0[15], w0[11], w0[14:12]});
         else
            chk(idx_reg == 3'd0 && !idx_long && !idx_areg, "R4 index zero",
                {27'd0, idx_areg, idx_long, idx_reg}, 32'd0);
         req_ready = 1'b0;
         @(negedge clk);
         #1;
         chk(done == 1'b0, "R9 single pulse", 32'(done), 32'd0);
         chk(ext_value == ev && opnd_kind == ek, poke ? "R11 start ignored while busy" : "R11 held",
             ext_value, ev);
      end
   endtask

   initial begin
      #23;
      chk(done == 1'b0 && illegal == 1'b0 && req_valid == 1'b0, "R11 reset flags",
          {29'd0, done, illegal, req_valid}, 32'd0);
      chk(ext_value == 32'd0 && pc_next == 32'd0 && opnd_kind == 4'd0, "R11 reset outputs",
          ext_value | pc_next | 32'(opnd_kind), 32'd0);
      rst_n = 1'b1;
      for (int d = 0; d < 2; d++) begin
         for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 8; r++) begin
               for (int sz = 0; sz < 4; sz++) begin
                  logic [31:0] pc;
                  pc = 32'h0001_0000 + 32'(((d * 8 + m) * 8 + r) * 40 + sz * 6);
                  if (m == 7 && r == 1 && sz == 3) pc = 32'hFFFF_FFFE;
                  run_case(d[0], m, r, sz, pc, sz[0], ((m + r + sz) % 5) == 0);
               end
            end
         end
      end
      summary();
      $finish;
   end
endmodule